// File: doc/BRIEF.md
# Programmable Divider with Phase Offset

This block divides its input clock by a programmable ratio. The high phase and the low phase of the divided output each have their own cycle count, so the block produces uneven duty cycles as readily as square waves. A sync strobe restarts the divider. While the strobe is held, the output stays low and the block takes a snapshot of all configuration fields. When the strobe is released, a start delay runs first, and then the divided waveform begins with a high phase.

The start delay comes from a phase value that combines a start-high bit and a phase-offset field. With the start-high bit clear, the delay equals the offset field. With the bit set, the delay also includes the programmed low time. Several instances can run from one input clock and share one sync strobe. Their outputs are then skewed by whole input-clock cycles, and each skew equals the difference of the programmed delays. This gives coarse output-to-output timing alignment.

Top module: `phase_divider`

## Requirements
- R1: After reset, `div_out` is 0 and stays 0 until `sync` has been sampled high at least once.
- R2: On every rising `clk` edge that samples `sync` high, `div_out` becomes 0 and the divider restarts. Release is the first edge that samples `sync` low after it was high.
- R3: Each high phase of `div_out` lasts `hi_len`+1 input cycles, where `hi_len` is the value captured at the last sync.
- R4: Between two high phases, each low phase lasts `lo_len`+1 input cycles, using the captured value.
- R5: With the captured `start_hi` = 0, the first rise of `div_out` comes `ph_off` cycles later than it would with zero offset. Zero offset gives a rise on the release edge itself. The rise therefore happens at release edge number `ph_off`+1, counting the release edge as number 1.
- R6: With the captured `start_hi` = 1, the delay is `ph_off` + `lo_len` + 1 cycles. The first rise happens at release edge number `ph_off` + `lo_len` + 2.
- R7: A change to `hi_len`, `lo_len`, `ph_off` or `start_hi` while `sync` is low does not change `div_out` until the next sync.
- R8: Two instances on the same clock and `sync` have first rises that differ by exactly the difference of their delays, in input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart strobe; the configuration fields are captured while it is high |
| hi_len | input | W (4) | High time minus 1, in input cycles |
| lo_len | input | W (4) | Low time minus 1, in input cycles |
| ph_off | input | W (4) | Phase-offset field |
| start_hi | input | 1 | Start-high bit; when set, the low time is added to the delay |
| div_out | output | 1 | Divided clock |

## Verification
The bench covers both ends of the delay range. At the low end, a zero delay gives a rise on the release edge itself; a design that loses that cycle shifts every output by one. At the high end, start-high with all fields at maximum gives the 31-cycle delay, which would wrap a counter that is one bit too narrow. The bench also rewrites every field in the middle of a run, to catch a design that reads live inputs instead of its snapshot. It sends a one-cycle sync in the middle of a high phase; a design that only restarts at a period boundary would leave a stale high pulse. The bench measures the skew between two instances at several offset pairs, including a mix of start-high and plain settings, so that a miscounted low-time term shows up as a wrong skew.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

    // Phases of the divided waveform
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phdiv_phase_e;

endpackage

// File: rtl/phdiv_cfg_reg.sv
module phdiv_cfg_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic [W-1:0] hi_len,
    input  logic [W-1:0] lo_len,
    output logic [W-1:0] hi_cap,
    output logic [W-1:0] lo_cap
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Fields are taken only while the restart strobe is high
    always_comb begin
        cfg_d = cfg_q;
        if (sync) begin
            cfg_d.hi = hi_len;
            cfg_d.lo = lo_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign hi_cap = cfg_q.hi;
    assign lo_cap = cfg_q.lo;

endmodule

// File: rtl/phdiv_delay_calc.sv
module phdiv_delay_calc #(
    parameter int W = 4,
    localparam int DW = W + 1
) (
    input  logic [W-1:0]  ph_off,
    input  logic          start_hi,
    input  logic [W-1:0]  lo_len,
    output logic [DW-1:0] delay
);

    logic [DW-1:0] off_ext;
    logic [DW-1:0] lo_ext;

    assign off_ext = {1'b0, ph_off};
    assign lo_ext  = {1'b0, lo_len};

    // Start-high folds the low time plus one extra cycle into the delay
    always_comb begin
        if (start_hi) begin
            delay = off_ext + lo_ext + DW'(1);
        end else begin
            delay = off_ext;
        end
    end

endmodule

// File: rtl/phdiv_wave_fsm.sv
module phdiv_wave_fsm
    import phdiv_pkg::*;
#(
    parameter int W = 4,
    localparam int DW = W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    input  logic [DW-1:0] delay_in,
    input  logic [W-1:0]  hi_cap,
    input  logic [W-1:0]  lo_cap,
    output logic          wave
);

    typedef struct packed {
        phdiv_phase_e  phase;
        logic [DW-1:0] cnt;
        logic          out;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sync) begin
            s_d.phase = PH_DELAY;
            s_d.cnt   = delay_in;
            s_d.out   = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.out = 1'b0;
                end
                PH_DELAY: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_HIGH;
                        s_d.cnt   = {1'b0, hi_cap};
                        s_d.out   = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - DW'(1);
                    end
                end
                PH_HIGH: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_LOW;
                        s_d.cnt   = {1'b0, lo_cap};
                        s_d.out   = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt - DW'(1);
                    end
                end
                PH_LOW: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_HIGH;
                        s_d.cnt   = {1'b0, hi_cap};
                        s_d.out   = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - DW'(1);
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.out   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.out   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wave = s_q.out;

endmodule

// File: rtl/phase_divider.sv
module phase_divider #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic [W-1:0] hi_len,
    input  logic [W-1:0] lo_len,
    input  logic [W-1:0] ph_off,
    input  logic         start_hi,
    output logic         div_out
);

    localparam int DW = W + 1;

    logic [W-1:0]  hi_cap;
    logic [W-1:0]  lo_cap;
    logic [DW-1:0] delay;

    phdiv_cfg_reg #(.W(W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync   (sync),
        .hi_len (hi_len),
        .lo_len (lo_len),
        .hi_cap (hi_cap),
        .lo_cap (lo_cap)
    );

    // Delay is derived from the live fields; it is loaded only on a sync edge
    phdiv_delay_calc #(.W(W)) u_delay (
        .ph_off   (ph_off),
        .start_hi (start_hi),
        .lo_len   (lo_len),
        .delay    (delay)
    );

    phdiv_wave_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (sync),
        .delay_in (delay),
        .hi_cap   (hi_cap),
        .lo_cap   (lo_cap),
        .wave     (div_out)
    );

endmodule

// File: rtl/phdiv_checker.sv
module phdiv_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sync,
    input logic [W-1:0] hi_len,
    input logic [W-1:0] lo_len,
    input logic [W-1:0] ph_off,
    input logic         start_hi,
    input logic         div_out
);

    localparam int CW = W + 3;
    localparam logic [CW-1:0] CMAX = '1;

    logic          armed;
    logic          prev_out;
    logic          seen_rise;
    logic [CW-1:0] run_len;
    logic [CW-1:0] since_rel;
    logic [W-1:0]  sh_hi, sh_lo, sh_off;
    logic          sh_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            prev_out  <= 1'b0;
            seen_rise <= 1'b0;
            run_len   <= '0;
            since_rel <= '0;
            sh_hi     <= '0;
            sh_lo     <= '0;
            sh_off    <= '0;
            sh_start  <= 1'b0;
        end else begin
            prev_out <= div_out;
            if (div_out != prev_out) begin
                run_len <= CW'(1);
            end else if (run_len != CMAX) begin
                run_len <= run_len + CW'(1);
            end
            if (sync) begin
                armed     <= 1'b1;
                seen_rise <= 1'b0;
                since_rel <= '0;
                sh_hi     <= hi_len;
                sh_lo     <= lo_len;
                sh_off    <= ph_off;
                sh_start  <= start_hi;
            end else begin
                if (since_rel != CMAX) begin
                    since_rel <= since_rel + CW'(1);
                end
                if (div_out && !prev_out) begin
                    seen_rise <= 1'b1;
                end
            end
        end
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !div_out);

    a_r2_sync_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !div_out);

    a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_out && !div_out && !$past(sync)) |-> (run_len == CW'(sh_hi) + CW'(1)));

    a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_out && div_out && seen_rise) |-> (run_len == CW'(sh_lo) + CW'(1)));

    a_r5_first_rise_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_out && div_out && !seen_rise && !sh_start)
            |-> (since_rel == CW'(sh_off) + CW'(1)));

    a_r6_first_rise_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_out && div_out && !seen_rise && sh_start)
            |-> (since_rel == CW'(sh_off) + CW'(sh_lo) + CW'(2)));

endmodule

bind phase_divider phdiv_checker #(.W(W)) u_phdiv_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (sync),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .ph_off   (ph_off),
    .start_hi (start_hi),
    .div_out  (div_out)
);

// File: tb/test_phase_divider.sv
module test_phase_divider;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [3:0] f_n [2];
    logic [3:0] f_m [2];
    logic [3:0] f_po [2];
    logic       f_sh [2];
    logic       out_a, out_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit r7_phase = 1'b0;

    // Reference model state per instance
    int  armed [2];
    int  k [2];
    int  cd [2];
    int  cn [2];
    int  cm [2];
    int  cs [2];
    int  rise_at [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_divider i_phase_divider (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .hi_len(f_n[0]), .lo_len(f_m[0]), .ph_off(f_po[0]), .start_hi(f_sh[0]),
        .div_out(out_a)
    );

    phase_divider i_phase_divider_b (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .hi_len(f_n[1]), .lo_len(f_m[1]), .ph_off(f_po[1]), .start_hi(f_sh[1]),
        .div_out(out_b)
    );

    function automatic int delay_of(int po, int sh, int m);
        return (sh != 0) ? (po + m + 1) : po;
    endfunction

    function automatic int expect_out(int i);
        if (armed[i] == 0 || k[i] == 0) return 0;
        if (k[i] <= cd[i]) return 0;
        return (((k[i] - cd[i] - 1) % (cn[i] + cm[i] + 2)) <= cn[i]) ? 1 : 0;
    endfunction

    function automatic string tag_of(int i);
        if (r7_phase) return "R7";
        if (armed[i] == 0) return "R1";
        if (k[i] == 0) return "R2";
        if (k[i] <= cd[i] + 1) return (cs[i] != 0) ? "R6" : "R5";
        if (((k[i] - cd[i] - 1) % (cn[i] + cm[i] + 2)) <= cn[i]) return "R3";
        return "R4";
    endfunction

    // Model advances on each rising edge from the inputs held since the last falling edge
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                armed[i] = 0;
                k[i] = 0;
            end else if (sync) begin
                armed[i] = 1;
                k[i] = 0;
                cn[i] = int'(f_n[i]);
                cm[i] = int'(f_m[i]);
                cs[i] = int'(f_sh[i]);
                cd[i] = delay_of(int'(f_po[i]), cs[i], cm[i]);
                rise_at[i] = -1;
            end else if (armed[i] != 0) begin
                k[i] = k[i] + 1;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                int a;
                int e;
                a = (i == 0) ? int'(out_a) : int'(out_b);
                e = expect_out(i);
                checks++;
                if (a != e) begin
                    failures++;
                    $display("FAIL %s inst=%0d k=%0d actual=%0d expected=%0d",
                             tag_of(i), i, k[i], a, e);
                end
                if (a == 1 && armed[i] != 0 && rise_at[i] < 0) rise_at[i] = k[i];
            end
        end
    end

    task automatic set_cfg(int i, int n, int m, int po, int sh);
        f_n[i] = 4'(n);
        f_m[i] = 4'(m);
        f_po[i] = 4'(po);
        f_sh[i] = sh[0];
    endtask

    task automatic pulse_sync(int n);
        @(negedge clk);
        sync = 1'b1;
        repeat (n) @(negedge clk);
        sync = 1'b0;
    endtask

    // R8: skew between the two first rises equals the delay difference
    task automatic check_skew();
        int exp_skew;
        int act_skew;
        exp_skew = cd[0] - cd[1];
        act_skew = rise_at[0] - rise_at[1];
        checks++;
        if (rise_at[0] < 0 || rise_at[1] < 0 || act_skew != exp_skew) begin
            failures++;
            $display("FAIL R8 skew actual=%0d expected=%0d", act_skew, exp_skew);
        end
    endtask

    initial begin
        set_cfg(0, 2, 1, 0, 0);
        set_cfg(1, 2, 1, 3, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_a !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b expected=0", out_a);
        end
        rst_n = 1'b1;
        repeat (10) @(negedge clk);   // R1: no sync yet, output must stay low

        // R5/R3/R4/R8: zero offset against offset 3
        pulse_sync(2);
        repeat (40) @(negedge clk);
        check_skew();

        // R6 against R5: start-high mixed with plain offset
        set_cfg(0, 0, 4, 2, 1);
        set_cfg(1, 1, 2, 5, 0);
        pulse_sync(1);
        repeat (60) @(negedge clk);
        check_skew();

        // Largest delay: start-high, all fields at maximum
        set_cfg(0, 15, 15, 15, 1);
        set_cfg(1, 15, 15, 0, 0);
        pulse_sync(3);
        repeat (130) @(negedge clk);
        check_skew();

        // R7: fields change while running, no effect expected
        set_cfg(0, 1, 2, 1, 0);
        set_cfg(1, 0, 0, 0, 0);
        pulse_sync(1);
        repeat (2) @(negedge clk);
        r7_phase = 1'b1;
        set_cfg(0, 7, 0, 9, 1);
        set_cfg(1, 5, 3, 2, 1);
        repeat (40) @(negedge clk);
        r7_phase = 1'b0;

        // R2: single-cycle sync arriving mid high phase
        set_cfg(0, 6, 3, 0, 0);
        set_cfg(1, 6, 3, 4, 1);
        pulse_sync(1);
        repeat (3) @(negedge clk);
        pulse_sync(1);
        repeat (50) @(negedge clk);
        check_skew();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule